// File: doc/BRIEF.md
# RFID Tag Protocol Controller

This block is the central sequencer of a passive tag's digital baseband. It runs on the bit clock recovered from the downlink and consumes already-demodulated bits, each one qualified by a valid strobe. From power-on reset it waits in a halt/detect state for a frame preamble, reads a three-bit command and then either answers in an anti-collision slot, programs the tag memory, or first proves that the reader addressed this particular tag by matching the stored data bit by bit.

The controller does not hold the slot counter, the transmit cache or the memory. It drives one-cycle strobes to them and reads their status lines back. It keeps the three status flags: an identified flag, a saturating count of failed transmissions and a permanent disable flag. The tag performs no integrity check on received data, because the reader handles all error detection.

Top module: `tag_proto_ctrl`

## Requirements
- R1: After reset all strobes are low, the identified and disable flags are 0 and the failure count is 0. The tag then searches for a frame start.
- R2: A frame start is a 1 bit that follows at least ten consecutive 0 bits. A 1 bit after nine or fewer zeros starts nothing.
- R3: The three bits after the frame start form the opcode, first bit most significant: 000 wake-all, 001 query-unidentified, 010 write, 011 modify, 100 kill. Any other code returns the tag to searching, with no strobe raised. At most one of tx_load, tx_start and mem_we is high in any cycle.
- R4: Wake-all always raises tx_load and slot_load together for one cycle, in the cycle after the last opcode bit. Query-unidentified does the same only while the identified flag is 0; otherwise it raises neither.
- R5: tx_start pulses for one cycle, one cycle after slot_zero is sampled high. slot_zero is not sampled in the cycle that slot_load is high. After tx_done the next valid bit is the reader's feedback, where 1 means acknowledged and 0 means failed.
- R6: An acknowledgement sets the identified flag and clears the failure count. A failure adds one to the 4-bit count, which stops at 15.
- R7: Write stores the next DATA_BITS bits without any check. The k-th bit received goes to address k, with one mem_we pulse per bit.
- R8: Modify and kill first compare DATA_BITS received bits with memory, bit k against address k. The first differing bit returns the tag to searching and skips the rest of the operation. On a full match, modify goes on to a write as in R7, and kill sets the disable flag.
- R9: Once the disable flag is set, it stays set until power-on reset. No command raises tx_load or mem_we while it is set.
- R10: After an operation completes or aborts, the tag searches for a new frame start, and a following frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered downlink bit clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Demodulated downlink bit |
| slot_zero | input | 1 | Slot counter has reached zero |
| tx_done | input | 1 | Transmit cache has finished sending |
| mem_rd_bit | input | 1 | Memory bit at mem_addr (combinational read) |
| slot_load | output | 1 | Load the slot counter with a new random value |
| tx_load | output | 1 | Load the transmit cache from memory |
| tx_start | output | 1 | Start the uplink transmission |
| mem_we | output | 1 | Memory bit write strobe |
| mem_addr | output | 4 | Memory bit address, used for writes and compares |
| mem_wdata | output | 1 | Bit to write |
| ack_flag | output | 1 | Tag has been identified |
| nak_count | output | 4 | Count of failed transmissions, saturating |
| kill_flag | output | 1 | Tag is permanently disabled |

## Verification
The assertions assume a cooperative slot counter and transmit cache. They take it that slot_zero and tx_done only matter while the controller waits for them, and that mem_rd_bit always reflects the memory at the registered mem_addr. The bench models the memory as a register array with that read behaviour. It holds slot_zero low until three cycles after a slot load, and raises tx_done only after tx_start has been seen. The data patterns it sends never contain ten zeros in a row, so an aborted access never produces a false frame start in the middle of a frame.

// File: rtl/tagctl_pkg.sv
`timescale 1ns/1ps
package tagctl_pkg;

  localparam int OP_W = 3;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_HALT,
    ST_CMD,
    ST_SLOT,
    ST_TXW,
    ST_FB,
    ST_WRITE,
    ST_ACCESS
  } tag_state_t;

  typedef enum logic [OP_W-1:0] {
    OP_WAKE   = 3'b000,
    OP_QUERY  = 3'b001,
    OP_WRITE  = 3'b010,
    OP_MODIFY = 3'b011,
    OP_KILL   = 3'b100
  } tag_op_t;

endpackage

// File: rtl/tag_sync_det.sv
`timescale 1ns/1ps
module tag_sync_det #(
  parameter int SYNC_ZEROS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_valid,
  input  logic bit_in,
  output logic sync_hit
);
  localparam int RW = $clog2(SYNC_ZEROS + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(SYNC_ZEROS);

  logic [RW-1:0] run;

  // Zero-run counter, saturating at the preamble length; cleared outside search.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run <= '0;
    end else if (bit_valid) begin
      if (bit_in)
        run <= '0;
      else if (run != RUN_MAX)
        run <= run + RW'(1);
    end
  end

  assign sync_hit = en && bit_valid && bit_in && (run == RUN_MAX);

endmodule

// File: rtl/tag_status_flags.sv
`timescale 1ns/1ps
module tag_status_flags #(
  parameter int NAK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_valid,
  input  logic             fb_ack,
  input  logic             kill_set,
  output logic             ack_q,
  output logic [NAK_W-1:0] nak_q,
  output logic             kill_q
);
  localparam logic [NAK_W-1:0] NAK_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      nak_q  <= '0;
      kill_q <= 1'b0;
    end else begin
      if (fb_valid) begin
        if (fb_ack) begin
          ack_q <= 1'b1;
          nak_q <= '0;
        end else if (nak_q != NAK_MAX) begin
          nak_q <= nak_q + NAK_W'(1);
        end
      end
      if (kill_set)
        kill_q <= 1'b1;
    end
  end

  a_r6_nak_saturates: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && !fb_ack && nak_q == NAK_MAX) |=> (nak_q == NAK_MAX));

  a_r6_ack_clears_nak: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && fb_ack) |=> (ack_q && nak_q == '0));

  a_r9_kill_sticky: assert property (@(posedge clk) disable iff (rst)
    kill_q |=> kill_q);

endmodule

// File: rtl/tag_proto_ctrl.sv
`timescale 1ns/1ps
module tag_proto_ctrl
  import tagctl_pkg::*;
#(
  parameter int DATA_BITS  = 16,
  parameter int NAK_W      = 4,
  parameter int SYNC_ZEROS = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bit_valid,
  input  logic                          bit_in,
  input  logic                          slot_zero,
  input  logic                          tx_done,
  input  logic                          mem_rd_bit,
  output logic                          slot_load,
  output logic                          tx_load,
  output logic                          tx_start,
  output logic                          mem_we,
  output logic [$clog2(DATA_BITS)-1:0]  mem_addr,
  output logic                          mem_wdata,
  output logic                          ack_flag,
  output logic [NAK_W-1:0]              nak_count,
  output logic                          kill_flag
);
  localparam int AW = $clog2(DATA_BITS);
  localparam logic [AW-1:0] LAST_IDX = AW'(DATA_BITS - 1);
  localparam logic [AW-1:0] OP_LAST  = AW'(OP_W - 1);

  tag_state_t       state;
  tag_op_t          cmd;
  logic [OP_W-2:0]  op_sr;
  logic [AW-1:0]    idx;
  logic [OP_W-1:0]  opv;
  logic             sync_hit;
  logic             fb_valid;
  logic             kill_set;
  logic             bit_match;

  tag_sync_det #(.SYNC_ZEROS(SYNC_ZEROS)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .en        (state == ST_HALT),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .sync_hit  (sync_hit)
  );

  assign opv       = {op_sr, bit_in};
  assign bit_match = (bit_in == mem_rd_bit);
  assign fb_valid  = (state == ST_FB) && bit_valid;
  assign kill_set  = (state == ST_ACCESS) && bit_valid && bit_match &&
                     (idx == LAST_IDX) && (cmd == OP_KILL);

  tag_status_flags #(.NAK_W(NAK_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .fb_valid (fb_valid),
    .fb_ack   (bit_in),
    .kill_set (kill_set),
    .ack_q    (ack_flag),
    .nak_q    (nak_count),
    .kill_q   (kill_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PWR;
      cmd       <= OP_WAKE;
      op_sr     <= '0;
      idx       <= '0;
      slot_load <= 1'b0;
      tx_load   <= 1'b0;
      tx_start  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 1'b0;
    end else begin
      slot_load <= 1'b0;
      tx_load   <= 1'b0;
      tx_start  <= 1'b0;
      mem_we    <= 1'b0;
      case (state)
        ST_PWR: state <= ST_HALT;

        ST_HALT: begin
          if (sync_hit) begin
            state <= ST_CMD;
            idx   <= '0;
          end
        end

        ST_CMD: begin
          if (bit_valid) begin
            op_sr <= opv[OP_W-2:0];
            idx   <= idx + AW'(1);
            if (idx == OP_LAST) begin
              idx      <= '0;
              mem_addr <= '0;
              state    <= ST_HALT;
              case (opv)
                OP_WAKE, OP_QUERY: begin
                  if (!kill_flag && (opv == OP_WAKE || !ack_flag)) begin
                    tx_load   <= 1'b1;
                    slot_load <= 1'b1;
                    state     <= ST_SLOT;
                  end
                end
                OP_WRITE:
                  if (!kill_flag) state <= ST_WRITE;
                OP_MODIFY, OP_KILL: begin
                  if (!kill_flag) begin
                    cmd   <= tag_op_t'(opv);
                    state <= ST_ACCESS;
                  end
                end
                default: state <= ST_HALT;
              endcase
            end
          end
        end

        ST_SLOT: begin
          if (slot_zero && !slot_load) begin
            tx_start <= 1'b1;
            state    <= ST_TXW;
          end
        end

        ST_TXW: if (tx_done) state <= ST_FB;

        ST_FB: if (bit_valid) state <= ST_HALT;

        ST_WRITE: begin
          if (bit_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= idx;
            mem_wdata <= bit_in;
            idx       <= idx + AW'(1);
            if (idx == LAST_IDX) begin
              idx   <= '0;
              state <= ST_HALT;
            end
          end
        end

        ST_ACCESS: begin
          if (bit_valid) begin
            if (!bit_match) begin
              idx   <= '0;
              state <= ST_HALT;
            end else if (idx == LAST_IDX) begin
              idx   <= '0;
              state <= (cmd == OP_MODIFY) ? ST_WRITE : ST_HALT;
            end else begin
              idx      <= idx + AW'(1);
              mem_addr <= idx + AW'(1);
            end
          end
        end

        default: state <= ST_HALT;
      endcase
    end
  end

  a_r9_killed_silent: assert property (@(posedge clk) disable iff (rst)
    kill_flag |-> (!tx_load && !mem_we));

  a_r5_start_after_slot: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(slot_zero));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_load, tx_start, mem_we}));

  a_r4_load_pairs_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_load) |-> slot_load);

endmodule

// File: tb/tag_proto_ctrl_test.sv
`timescale 1ns/1ps
module tag_proto_ctrl_test;
  localparam int DB = 16;
  localparam int AW = $clog2(DB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0, bit_in = 1'b0, slot_zero = 1'b0, tx_done = 1'b0;
  logic mem_rd_bit;
  logic slot_load, tx_load, tx_start, mem_we, mem_wdata, ack_flag, kill_flag;
  logic [AW-1:0] mem_addr;
  logic [3:0] nak_count;

  int tests = 0, fails = 0;
  int n_txload = 0, n_memwe = 0;

  always #2.5 clk = ~clk;

  tag_proto_ctrl #(.DATA_BITS(DB), .NAK_W(4), .SYNC_ZEROS(10)) uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .slot_zero(slot_zero), .tx_done(tx_done), .mem_rd_bit(mem_rd_bit),
    .slot_load(slot_load), .tx_load(tx_load), .tx_start(tx_start),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ack_flag(ack_flag), .nak_count(nak_count), .kill_flag(kill_flag)
  );

  // Memory attached to the controller (stimulus side, not the reference).
  logic [DB-1:0] mem_img = '0;
  always @(posedge clk) if (mem_we) mem_img[mem_addr] <= mem_wdata;
  assign mem_rd_bit = mem_img[mem_addr];

  // Behavioural reference model of the protocol.
  int ms = 0;          // 0 search,1 opcode,2 feedback,3 write,4 access,5 transmitting
  int zr = 0, cnt = 0, opv = 0, mcmd = 0;
  bit exp_ack = 0, exp_kill = 0;
  int exp_nak = 0;
  logic [DB-1:0] exp_mem = '0;

  function automatic void model_bit(input logic b);
    case (ms)
      0: begin
        if (!b) begin if (zr < 10) zr++; end
        else begin if (zr >= 10) begin ms = 1; cnt = 0; opv = 0; end zr = 0; end
      end
      1: begin
        opv = ((opv << 1) | int'(b)) & 7; cnt++;
        if (cnt == 3) begin
          cnt = 0;
          case (opv)
            0: ms = exp_kill ? 0 : 5;
            1: ms = (exp_kill || exp_ack) ? 0 : 5;
            2: ms = exp_kill ? 0 : 3;
            3, 4: begin if (exp_kill) ms = 0; else begin ms = 4; mcmd = opv; end end
            default: ms = 0;
          endcase
        end
      end
      2: begin
        if (b) begin exp_ack = 1; exp_nak = 0; end
        else if (exp_nak < 15) exp_nak++;
        ms = 0;
      end
      3: begin
        exp_mem[cnt] = b; cnt++;
        if (cnt == DB) begin cnt = 0; ms = 0; end
      end
      4: begin
        if (b != exp_mem[cnt]) begin ms = 0; cnt = 0; end
        else if (cnt == DB - 1) begin
          cnt = 0;
          if (mcmd == 3) ms = 3; else begin exp_kill = 1; ms = 0; end
        end else cnt++;
      end
      default: ;
    endcase
    if (ms != 0) zr = 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Per-clock comparison of the status flags against the model.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (tx_load) n_txload++;
      if (mem_we) n_memwe++;
      chk(ack_flag == exp_ack, "R6 ack_flag", int'(ack_flag), int'(exp_ack));
      chk(int'(nak_count) == exp_nak, "R6 nak_count", int'(nak_count), exp_nak);
      chk(kill_flag == exp_kill, "R9 kill_flag", int'(kill_flag), int'(exp_kill));
    end
  end

  task automatic send_bit(input logic b);
    model_bit(b);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b0;
  endtask

  task automatic send_sync(input int nz);
    for (int i = 0; i < nz; i++) send_bit(1'b0);
    send_bit(1'b1);
  endtask

  task automatic send_cmd(input logic [2:0] op);
    send_sync(10);
    for (int i = 2; i >= 0; i--) send_bit(op[i]);
  endtask

  task automatic send_data(input logic [DB-1:0] d);
    for (int i = 0; i < DB; i++) send_bit(d[i]);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    ms = 0; zr = 0; cnt = 0; exp_ack = 0; exp_nak = 0; exp_kill = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Called at the negedge right after the last opcode bit of a responding frame.
  task automatic do_tx(input logic fb, input string req);
    chk(tx_load && slot_load, {req, " R4 load strobes"}, int'({tx_load, slot_load}), 3);
    repeat (3) @(negedge clk);
    chk(!tx_start, "R5 waits for slot", int'(tx_start), 0);
    slot_zero = 1'b1;
    @(negedge clk);
    slot_zero = 1'b0;
    chk(tx_start, "R5 start after slot zero", int'(tx_start), 1);
    @(negedge clk);
    chk(!tx_start, "R5 start one cycle", int'(tx_start), 0);
    tx_done = 1'b1; ms = 2;
    @(negedge clk);
    tx_done = 1'b0;
    send_bit(fb);
    @(negedge clk);
  endtask

  task automatic expect_silent(input logic [2:0] op, input string req);
    int t0;
    t0 = n_txload;
    send_cmd(op);
    @(negedge clk);
    chk(n_txload == t0, req, n_txload - t0, 0);
  endtask

  initial begin
    int t0, w0;
    logic [DB-1:0] pa, pb, bad;
    pa = 16'hA5C3;
    pb = 16'h3C96;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk({slot_load, tx_load, tx_start, mem_we} == 4'b0, "R1 strobes idle",
        int'({slot_load, tx_load, tx_start, mem_we}), 0);
    chk(!ack_flag && nak_count == 0 && !kill_flag, "R1 flags clear",
        int'({ack_flag, nak_count, kill_flag}), 0);

    // R2 nine zeros do not start a frame
    t0 = n_txload;
    send_sync(9);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    repeat (2) @(negedge clk);
    chk(n_txload == t0, "R2 short preamble ignored", n_txload - t0, 0);

    // R4/R5/R6 wake-all then failure
    send_cmd(3'b000);
    do_tx(1'b0, "wake");
    chk(nak_count == 1, "R6 nak increments", int'(nak_count), 1);
    // query-unidentified responds while unidentified, then acknowledged
    send_cmd(3'b001);
    chk(ms == 5, "R4 query expected response", ms, 5);
    do_tx(1'b1, "query");
    chk(ack_flag && nak_count == 0, "R6 ack clears nak", int'({ack_flag, nak_count}), 16);
    // R4 query ignored once identified
    expect_silent(3'b001, "R4 query silent when identified");
    // R6 saturation
    for (int k = 0; k < 17; k++) begin
      send_cmd(3'b000);
      do_tx(1'b0, "wake-sat");
    end
    chk(nak_count == 15, "R6 nak saturates", int'(nak_count), 15);

    // R3 unknown opcodes
    t0 = n_txload; w0 = n_memwe;
    send_cmd(3'b111);
    send_cmd(3'b101);
    repeat (2) @(negedge clk);
    chk(n_txload == t0 && n_memwe == w0, "R3 unknown opcode no strobe",
        (n_txload - t0) + (n_memwe - w0), 0);
    // R10 next frame decoded normally
    send_cmd(3'b000);
    do_tx(1'b1, "R10 after unknown");
    chk(nak_count == 0, "R10 frame after abort", int'(nak_count), 0);

    // R7 write
    w0 = n_memwe;
    send_cmd(3'b010);
    send_data(pa);
    repeat (2) @(negedge clk);
    chk(mem_img == exp_mem && mem_img == pa, "R7 write data", int'(mem_img), int'(pa));
    chk(n_memwe - w0 == DB, "R7 one write per bit", n_memwe - w0, DB);

    // R8 modify with mismatch at bit 5
    bad = pa ^ 16'h0020;
    w0 = n_memwe;
    send_cmd(3'b011);
    send_data(bad);
    send_data(pb);
    repeat (2) @(negedge clk);
    chk(n_memwe == w0, "R8 mismatch aborts modify", n_memwe - w0, 0);
    chk(mem_img == pa, "R8 memory unchanged", int'(mem_img), int'(pa));

    // R8 modify with match
    send_cmd(3'b011);
    send_data(pa);
    send_data(pb);
    repeat (2) @(negedge clk);
    chk(mem_img == pb && mem_img == exp_mem, "R8 modify writes", int'(mem_img), int'(pb));

    // R8 kill with mismatch on last bit
    send_cmd(3'b100);
    send_data(pb ^ 16'h8000);
    repeat (2) @(negedge clk);
    chk(!kill_flag, "R8 kill mismatch keeps tag", int'(kill_flag), 0);

    // R8/R9 kill with match
    send_cmd(3'b100);
    send_data(pb);
    repeat (2) @(negedge clk);
    chk(kill_flag, "R9 kill sets flag", int'(kill_flag), 1);

    // R9 disabled tag is silent
    expect_silent(3'b000, "R9 wake silent when killed");
    w0 = n_memwe;
    send_cmd(3'b010);
    send_data(pa);
    repeat (2) @(negedge clk);
    chk(n_memwe == w0 && mem_img == pb, "R9 write refused when killed", n_memwe - w0, 0);

    // R1 power-on reset clears flags
    do_reset();
    chk(!kill_flag && !ack_flag && nak_count == 0, "R1 flags clear after reset",
        int'({ack_flag, nak_count, kill_flag}), 0);
    send_cmd(3'b000);
    do_tx(1'b1, "R1 alive after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule